// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block watches a BCD time of day that a separate timekeeping circuit supplies. It raises a sticky alarm flag when that time agrees with a programmed alarm. Four alarm bytes are held: seconds, minutes, hours and day of month. Bit 7 of each byte removes its field from the comparison. Only the nested mask patterns are accepted. In order, these ignore every field, check seconds alone, check seconds and minutes, check seconds, minutes and hours, or check all four fields. Any other pattern never produces a match.

The comparison is made only on cycles where the one-second tick is high, so each tick that matches produces one set event. Software programs the block through a small write port. The alarm bytes sit at consecutive addresses, and the interrupt enable and the status flag each have their own address. The flag stays high until software clears it. The active-low interrupt line follows the flag whenever the enable bit is set.

Top module: `tod_alarm_match`

## Requirements
- R1: A write to address 0x07, 0x08, 0x09 or 0x0A loads the seconds, minutes, hours or day alarm byte, in that order. The new value appears on the matching readback output one cycle later. A write to any other address leaves all four alarm bytes unchanged.
- R2: When bit 7 is set in all four alarm bytes (mask code {sec,min,hour,day} = 4'b1111), every tick sets the alarm flag.
- R3: The mask code selects which fields are compared. 4'b0111 compares seconds. 4'b0011 compares seconds and minutes. 4'b0001 compares seconds, minutes and hours. 4'b0000 compares all four fields. A tick sets the flag only if every compared field equals the current time.
- R4: The hours alarm byte keeps bit 7 and bits 5:0 of the written data. Its bit 6 always reads 0. The seconds, minutes and day bytes keep all 8 bits, and their low 7 bits are compared.
- R5: The flag is never set in a cycle without a tick, even when the fields match.
- R6: Any mask code other than the five legal ones never sets the flag.
- R7: The flag is sticky. A write to address 0x10 with data bit 0 = 0 clears it. A write there with bit 0 = 1 leaves it unchanged.
- R8: Bit 0 of a write to address 0x0F sets the interrupt enable. `irq_n` is 0 exactly when the flag and the enable are both 1.
- R9: If a tick-driven set and a clear write fall in the same cycle, the flag ends up set.
- R10: After reset, the alarm bytes are 0x00, the flag is 0, the enable is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_day | input | 7 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| alm_sec_o | output | 8 | Seconds alarm byte readback |
| alm_min_o | output | 8 | Minutes alarm byte readback |
| alm_hour_o | output | 8 | Hours alarm byte readback |
| alm_day_o | output | 8 | Day alarm byte readback |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Each legal mask mode is first tried with a current time that agrees with the alarm. It is then tried with only the next field outward made to differ. This tells a mode that compares the right fields apart from one that compares too few or too many. Two illegal codes are applied while every field matches, which separates rejection of the code from field inequality. A match held without a tick shows that the comparison is gated by the tick. Clear writes with bit 0 high and low, and a clear that coincides with a set, show the flag's priority. Toggling the enable separates the flag from the interrupt line.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WIDE_W     = 7;   // sec, min, day compare width
  localparam int unsigned HOUR_W     = 6;   // hours compare width
  localparam int unsigned HOUR_IDX   = 2;

  // mask code {sec,min,hour,day}
  localparam logic [3:0] CODE_EVERY = 4'b1111;
  localparam logic [3:0] CODE_S     = 4'b0111;
  localparam logic [3:0] CODE_SM    = 4'b0011;
  localparam logic [3:0] CODE_SMH   = 4'b0001;
  localparam logic [3:0] CODE_ALL   = 4'b0000;

  function automatic logic [BYTE_W-1:0] keep_bits(input int unsigned idx);
    return (idx == HOUR_IDX) ? 8'hBF : 8'hFF;
  endfunction
endpackage

// File: rtl/tam_alarm_regs.sv
module tam_alarm_regs
  import tam_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BASE   = 7
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [BYTE_W-1:0]                   wr_data,
  output logic [NUM_FIELDS-1:0][BYTE_W-1:0]   bytes_q
);
  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] byte_d;
    logic              byte_ld;

    always_comb begin
      byte_ld = wr_en && (wr_addr == ADDR_W'(BASE + gi));
      byte_d  = wr_data & keep_bits(gi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (byte_ld) byte_q <= byte_d;
    end

    assign bytes_q[gi] = byte_q;
  end
endmodule

// File: rtl/tam_match_unit.sv
module tam_match_unit
  import tam_pkg::*;
(
  input  logic [3:0]        mask_code,
  input  logic [WIDE_W-1:0] alm_sec,
  input  logic [WIDE_W-1:0] alm_min,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [WIDE_W-1:0] alm_day,
  input  logic [WIDE_W-1:0] cur_sec,
  input  logic [WIDE_W-1:0] cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [WIDE_W-1:0] cur_day,
  output logic              hit
);
  logic eq_s, eq_m, eq_h, eq_d;

  always_comb begin
    eq_s = (alm_sec  == cur_sec);
    eq_m = (alm_min  == cur_min);
    eq_h = (alm_hour == cur_hour);
    eq_d = (alm_day  == cur_day);
    case (mask_code)
      CODE_EVERY: hit = 1'b1;
      CODE_S:     hit = eq_s;
      CODE_SM:    hit = eq_s & eq_m;
      CODE_SMH:   hit = eq_s & eq_m & eq_h;
      CODE_ALL:   hit = eq_s & eq_m & eq_h & eq_d;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tam_flag_ctrl.sv
module tam_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic clr_req,
  input  logic en_ld,
  input  logic en_val,
  output logic flag_q,
  output logic en_q,
  output logic irq_n
);
  logic flag_d;
  logic en_d;

  always_comb begin
    if (tick && hit)  flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_q;
    en_d = en_ld ? en_val : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign irq_n = ~(flag_q & en_q);
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tam_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned ALARM_BASE = 7,
  parameter int unsigned CTRL_ADDR  = 15,
  parameter int unsigned STAT_ADDR  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic [6:0]        cur_sec,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [6:0]        cur_day,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        alm_sec_o,
  output logic [7:0]        alm_min_o,
  output logic [7:0]        alm_hour_o,
  output logic [7:0]        alm_day_o,
  output logic              alarm_flag,
  output logic              irq_n
);
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] bytes_q;
  logic [3:0] mask_code;
  logic       hit;
  logic       clr_req;
  logic       en_ld;
  logic       en_q;

  tam_alarm_regs #(.ADDR_W(ADDR_W), .BASE(ALARM_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bytes_q(bytes_q)
  );

  assign mask_code = {bytes_q[0][7], bytes_q[1][7], bytes_q[2][7], bytes_q[3][7]};

  tam_match_unit u_match (
    .mask_code(mask_code),
    .alm_sec(bytes_q[0][WIDE_W-1:0]), .alm_min(bytes_q[1][WIDE_W-1:0]),
    .alm_hour(bytes_q[2][HOUR_W-1:0]), .alm_day(bytes_q[3][WIDE_W-1:0]),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .hit(hit)
  );

  assign clr_req = wr_en && (wr_addr == ADDR_W'(STAT_ADDR)) && !wr_data[0];
  assign en_ld   = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  tam_flag_ctrl u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick_1s), .hit(hit), .clr_req(clr_req),
    .en_ld(en_ld), .en_val(wr_data[0]), .flag_q(alarm_flag), .en_q(en_q),
    .irq_n(irq_n)
  );

  assign alm_sec_o  = bytes_q[0];
  assign alm_min_o  = bytes_q[1];
  assign alm_hour_o = bytes_q[2];
  assign alm_day_o  = bytes_q[3];
endmodule

// File: rtl/tam_checker.sv
module tam_checker #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned STAT_ADDR = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1s,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        alm_sec_o,
  input logic [7:0]        alm_min_o,
  input logic [7:0]        alm_hour_o,
  input logic [7:0]        alm_day_o,
  input logic              alarm_flag,
  input logic              irq_n
);
  logic [3:0] code;
  logic       code_ok;
  logic       stat_wr;

  always_comb begin
    code    = {alm_sec_o[7], alm_min_o[7], alm_hour_o[7], alm_day_o[7]};
    code_ok = (code == 4'b1111) || (code == 4'b0111) || (code == 4'b0011) ||
              (code == 4'b0001) || (code == 4'b0000);
    stat_wr = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));
  end

  AST_EVERY_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && code == 4'b1111) |=> alarm_flag); // R2
  AST_HOUR_BIT6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !alm_hour_o[6]); // R4
  AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick_1s)); // R5
  AST_BAD_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && tick_1s && !code_ok) |=> !alarm_flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1s && !stat_wr) |=> $stable(alarm_flag)); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_flag |-> irq_n); // R8
endmodule

bind tod_alarm_match tam_checker #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_en(wr_en), .wr_addr(wr_addr),
  .alm_sec_o(alm_sec_o), .alm_min_o(alm_min_o), .alm_hour_o(alm_hour_o),
  .alm_day_o(alm_day_o), .alarm_flag(alarm_flag), .irq_n(irq_n)
);

// File: tb/tod_alarm_match_tb.sv
module tod_alarm_match_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1s;
  logic [6:0] cur_sec, cur_min, cur_day;
  logic [5:0] cur_hour;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] alm_sec_o, alm_min_o, alm_hour_o, alm_day_o;
  logic       alarm_flag, irq_n;

  int total = 0;
  int bad   = 0;
  string cur_req = "R10";

  // reference model state
  int  m_alm [4];
  bit  m_flag;
  bit  m_en;

  always #4 clk = ~clk;

  tod_alarm_match dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alm_sec_o(alm_sec_o), .alm_min_o(alm_min_o), .alm_hour_o(alm_hour_o),
    .alm_day_o(alm_day_o), .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  function automatic bit model_match();
    int code;
    bit s, mi, h, d;
    code = (m_alm[0] / 128) * 8 + (m_alm[1] / 128) * 4 + (m_alm[2] / 128) * 2 + (m_alm[3] / 128);
    s  = (m_alm[0] % 128) == int'(cur_sec);
    mi = (m_alm[1] % 128) == int'(cur_min);
    h  = (m_alm[2] % 64)  == int'(cur_hour);
    d  = (m_alm[3] % 128) == int'(cur_day);
    if (code == 15) return 1'b1;
    if (code == 7)  return s;
    if (code == 3)  return s && mi;
    if (code == 1)  return s && mi && h;
    if (code == 0)  return s && mi && h && d;
    return 1'b0;
  endfunction

  task automatic chk(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(alm_sec_o,  m_alm[0], "alm_sec");
    chk(alm_min_o,  m_alm[1], "alm_min");
    chk(alm_hour_o, m_alm[2], "alm_hour");
    chk(alm_day_o,  m_alm[3], "alm_day");
    chk(alarm_flag, m_flag, "flag");
    chk(irq_n, !(m_flag && m_en), "irq_n");
  endtask

  task automatic step(input bit tk, input bit we, input int a, input int d);
    bit set_now, clr_now;
    @(negedge clk);
    tick_1s = tk; wr_en = we; wr_addr = 5'(a); wr_data = 8'(d);
    @(posedge clk);
    set_now = tk && model_match();
    clr_now = we && a == 16 && (d % 2) == 0;
    if (set_now)      m_flag = 1'b1;
    else if (clr_now) m_flag = 1'b0;
    if (we) begin
      if (a >= 7 && a <= 10) m_alm[a-7] = (a == 9) ? (d & 'hBF) : d;
      if (a == 15) m_en = (d % 2) == 1;
    end
    #1;
    compare_all();
    @(negedge clk);
    tick_1s = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic expect_flag(input bit e, input string req);
    cur_req = req;
    chk(alarm_flag, e, "explicit flag");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; tick_1s = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cur_sec = 7'h30; cur_min = 7'h15; cur_hour = 6'h12; cur_day = 7'h21;
    for (int i = 0; i < 4; i++) m_alm[i] = 0;
    m_flag = 1'b0; m_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R10"; compare_all();
    @(negedge clk); rst_n = 1'b1;

    // R1: program alarm bytes, stray write ignored
    cur_req = "R1";
    wr(7, 'h30); wr(8, 'h15); wr(9, 'h12); wr(10, 'h21);
    chk(alm_sec_o, 'h30, "R1 sec readback");
    chk(alm_day_o, 'h21, "R1 day readback");
    wr(3, 'hFF);
    chk(alm_min_o, 'h15, "R1 stray write min");
    chk(alm_hour_o, 'h12, "R1 stray write hour");

    // R4: hours byte bit 6 dropped
    cur_req = "R4";
    wr(9, 'h7F);
    chk(alm_hour_o, 'h3F, "R4 hour bit6");
    wr(9, 'h12);

    // R5: match without tick does nothing
    cur_req = "R5";
    step(1'b0, 1'b0, 0, 0);
    expect_flag(1'b0, "R5");

    // R3: all-field mode
    cur_req = "R3";
    step(1'b1, 1'b0, 0, 0); expect_flag(1'b1, "R3");
    cur_req = "R7";
    wr(16, 'h01); expect_flag(1'b1, "R7");
    wr(16, 'hFE); expect_flag(1'b0, "R7");
    cur_req = "R3";
    cur_day = 7'h22;
    step(1'b1, 1'b0, 0, 0); expect_flag(1'b0, "R3");
    // seconds/minutes/hours mode
    wr(10, 'hA1);
    step(1'b1, 1'b0, 0, 0); expect_flag(1'b1, "R3");
    wr(16, 0);
    cur_hour = 6'h13;
    step(1'b1, 1'b0, 0, 0); expect_flag(1'b0, "R3");
    // seconds/minutes mode
    wr(9, 'h92);
    step(1'b1, 1'b0, 0, 0); expect_flag(1'b1, "R3");
    wr(16, 0);
    cur_min = 7'h16;
    step(1'b1, 1'b0, 0, 0); expect_flag(1'b0, "R3");
    // seconds only mode
    wr(8, 'h95);
    step(1'b1, 1'b0, 0, 0); expect_flag(1'b1, "R3");
    wr(16, 0);
    cur_sec = 7'h31;
    step(1'b1, 1'b0, 0, 0); expect_flag(1'b0, "R3");

    // R2: every-second mode
    cur_req = "R2";
    wr(7, 'hB0);
    step(1'b1, 1'b0, 0, 0); expect_flag(1'b1, "R2");

    // R8: enable gates interrupt
    cur_req = "R8";
    chk(irq_n, 1, "R8 irq while disabled");
    wr(15, 'h01);
    chk(irq_n, 0, "R8 irq enabled");

    // R9: set beats clear
    cur_req = "R9";
    wr(16, 0);
    step(1'b1, 1'b1, 16, 0); expect_flag(1'b1, "R9");
    cur_req = "R8";
    wr(16, 0);
    chk(irq_n, 1, "R8 irq after clear");
    wr(15, 'hFE);

    // R6: illegal codes with all fields matching
    cur_req = "R6";
    cur_sec = 7'h30; cur_min = 7'h15; cur_hour = 6'h12; cur_day = 7'h21;
    wr(7, 'h30); wr(8, 'h95); wr(9, 'h12); wr(10, 'hA1);
    step(1'b1, 1'b0, 0, 0); expect_flag(1'b0, "R6");
    wr(7, 'hB0); wr(8, 'h15); wr(10, 'h21);
    step(1'b1, 1'b0, 0, 0); expect_flag(1'b0, "R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule